// File: doc/BRIEF.md
# UART Interrupt Status and Clear Unit

This unit gathers the interrupt sources of a UART into one raw status word, lets software acknowledge them one by one, and drives a single interrupt line built from the bits software has enabled. Most sources are one-cycle event pulses from the UART core: DMA completion in each direction, a 9-bit address match, end of transmission, overrun, break, parity, framing, receive timeout, and changes on the four modem lines. Each pulse latches its flag until software clears it.

The transmit and receive flags work differently. They watch the FIFO fill levels and set or clear themselves when a level crosses a programmable trigger point. Holding a level beyond the trigger does not set them again. With the FIFOs turned off, the flags follow the single holding register instead. A control bit switches the meaning of the transmit flag to end of transmission. The receive-timeout flag is always latched, but it appears in the status words only while its mask bit is set.

Software reaches the unit through a small register port with a write strobe and a combinational read path. Raw status is at address 0. The mask is at address 1. The masked status is at address 2 and is read-only. The write-1-to-clear register is at address 3 and is write-only. Control is at address 4.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset the raw status, mask, masked status and control registers all read 0 and `irq_o` is low.
- R2: An `evt_i` pulse on bit 17 (TX DMA done), 16 (RX DMA done), 12 (address match), 11 (end of transmission), 10 (overrun), 9 (break), 8 (parity), 7 (framing), 6 (receive timeout), or 3..0 (DSR, DCD, CTS, RI) sets the same raw bit (address 0) at the next edge. Bits 4 and 5 and the reserved positions 31:18 and 15:13 of `evt_i` are ignored, and those reserved positions always read 0.
- R3: The masked status (address 2) equals raw AND mask (address 1, read/write), and `irq_o` is high exactly when any masked bit is 1.
- R4: Writing 1 to a bit of the clear register (address 3) clears that raw bit at the next edge. Clear bits written as 0 leave their flags unchanged, and writes to address 0 change nothing.
- R5: If a set event and a clear of the same bit fall in the same cycle, the bit ends up set.
- R6: FIFO mode, receive flag (bit 4): the flag sets when the receive level moves from below the trigger to at or above it. It clears when the level moves from at or above the trigger to below it. Staying on one side changes nothing.
- R7: FIFO mode with end-of-transmission mode off, transmit flag (bit 5): the flag sets when the transmit level moves from above the trigger to at or below it. It clears when the level moves from at or below the trigger to above it.
- R8: With the FIFOs off, the receive flag sets when `rx_level_i` goes from 0 to nonzero, and a `rx_rd_i` pulse clears it. The transmit flag sets when `tx_level_i` drops to 0, and a `tx_wr_i` pulse clears it.
- R9: With end-of-transmission mode on, the transmit flag sets together with bit 11 on an `evt_i` bit 11 pulse, and FIFO level crossings no longer set it.
- R10: The receive-timeout flag (bit 6) stays latched internally. It shows in the raw and masked status only while mask bit 6 is 1.
- R11: Control register (address 4) layout: bit 0 enables the FIFOs, bit 1 turns on end-of-transmission mode, bits 4:2 select the transmit trigger and bits 7:5 select the receive trigger. Select codes 0..4 give levels 2, 4, 8, 12 and 14 of a 16-entry FIFO, and codes 5..7 give 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 32 | One-cycle event pulses, aligned to raw status bit positions |
| tx_level_i | input | 5 | Transmit FIFO fill level |
| rx_level_i | input | 5 | Receive FIFO fill level |
| tx_wr_i | input | 1 | Byte written to the transmit holding register |
| rx_rd_i | input | 1 | Byte read from the receive holding register |
| reg_addr_i | input | 3 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Combined masked interrupt |

## Verification
A table drives both FIFO levels through paired sequences: rising across the trigger, falling across it, staying on one side of it, and jumping from one end to the other. This separates detection on a crossing from detection on a level. The bench also sweeps every trigger select code, moving the level one step below the expected trigger and then onto it, which pins down the encoding. Directed cases set and clear the flags in the same cycle, write 0 clears and writes to the read-only address, and hide and show the timeout bit through its mask. They also compare FIFO-off and end-of-transmission behaviour with the crossing behaviour, using the same level moves.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   localparam int unsigned STAT_W = 32;
   localparam int unsigned ADDR_W = 3;

   localparam int unsigned B_RX_FIFO = 4;
   localparam int unsigned B_TX_FIFO = 5;
   localparam int unsigned B_TIMEOUT = 6;
   localparam int unsigned B_EOT     = 11;

   localparam logic [STAT_W-1:0] IMPL_MASK = 32'h0003_1FFF;
   localparam logic [STAT_W-1:0] FIFO_BITS =
      (STAT_W'(1) << B_TX_FIFO) | (STAT_W'(1) << B_RX_FIFO);

   localparam logic [ADDR_W-1:0] A_RAW  = 3'd0;
   localparam logic [ADDR_W-1:0] A_MASK = 3'd1;
   localparam logic [ADDR_W-1:0] A_MIS  = 3'd2;
   localparam logic [ADDR_W-1:0] A_CLR  = 3'd3;
   localparam logic [ADDR_W-1:0] A_CTRL = 3'd4;

   typedef struct packed {
      logic [2:0] rx_sel;
      logic [2:0] tx_sel;
      logic       eot_mode;
      logic       fifo_en;
   } ctrl_t;

   localparam int unsigned CTRL_W = $bits(ctrl_t);

   function automatic int unsigned trig_level(logic [2:0] sel, int unsigned depth);
      case (sel)
         3'd0:    return depth / 8;
         3'd1:    return depth / 4;
         3'd2:    return depth / 2;
         3'd3:    return (depth * 3) / 4;
         3'd4:    return (depth * 7) / 8;
         default: return depth / 2;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_xing.sv
module uart_irq_xing #(
   parameter int unsigned LVL_W  = 5,
   parameter bit          DRAIN  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] level_i,
   input  logic [LVL_W-1:0] thr_i,
   output logic             up_o,
   output logic             down_o,
   output logic             edge_o
);

   logic [LVL_W-1:0] prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= level_i;
   end

   assign up_o   = (prev_q <  thr_i) && (level_i >= thr_i);
   assign down_o = (prev_q >= thr_i) && (level_i <  thr_i);

   generate
      if (DRAIN) begin : g_to_empty
         assign edge_o = (prev_q != '0) && (level_i == '0);
      end else begin : g_from_empty
         assign edge_o = (prev_q == '0) && (level_i != '0);
      end
   endgenerate

   // R6: an upward crossing leaves the stored level at or above the old trigger
   a_r6_up_lands_above: assert property (@(posedge clk) disable iff (!rst_n)
      up_o |=> (prev_q >= $past(thr_i)));

endmodule

// File: rtl/uart_irq_stat.sv
module uart_irq_stat #(
   parameter int unsigned         W    = 32,
   parameter logic [W-1:0]        IMPL = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q_o
);

   logic unused_rsvd;
   assign unused_rsvd = ^{set_i & ~IMPL, clr_i & ~IMPL};

   generate
      for (genvar i = 0; i < W; i++) begin : g_bit
         if (IMPL[i]) begin : g_flag
            logic q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)        q <= 1'b0;
               else if (set_i[i]) q <= 1'b1;
               else if (clr_i[i]) q <= 1'b0;
            end
            assign q_o[i] = q;

            // R5: a set in the same cycle as a clear keeps the flag
            a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
               set_i[i] |=> q_o[i]);
            // R4: without a clear, a set flag holds
            a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
               (q_o[i] && !clr_i[i]) |=> q_o[i]);
         end else begin : g_rsvd
            assign q_o[i] = 1'b0;
         end
      end
   endgenerate

endmodule

// File: rtl/uart_irq_regs.sv
module uart_irq_regs
   import uart_irq_pkg::*;
#(
   parameter int unsigned DW = STAT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic [DW-1:0]     wdata_i,
   input  logic [DW-1:0]     raw_vis_i,
   output logic [DW-1:0]     rdata_o,
   output logic [DW-1:0]     mask_o,
   output logic [DW-1:0]     clr_o,
   output ctrl_t             ctrl_o,
   output logic              irq_o
);

   logic [DW-1:0]     mask_q;
   logic [CTRL_W-1:0] ctrl_q;
   logic [DW-1:0]     mis;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         ctrl_q <= '0;
      end else if (wr_i) begin
         if (addr_i == A_MASK) mask_q <= wdata_i & IMPL_MASK;
         if (addr_i == A_CTRL) ctrl_q <= wdata_i[CTRL_W-1:0];
      end
   end

   assign clr_o  = (wr_i && addr_i == A_CLR) ? (wdata_i & IMPL_MASK) : '0;
   assign mask_o = mask_q;
   assign ctrl_o = ctrl_t'(ctrl_q);
   assign mis    = raw_vis_i & mask_q;
   assign irq_o  = |mis;

   always_comb begin
      case (addr_i)
         A_RAW:   rdata_o = raw_vis_i;
         A_MASK:  rdata_o = mask_q;
         A_MIS:   rdata_o = mis;
         A_CTRL:  rdata_o = DW'(ctrl_q);
         default: rdata_o = '0;
      endcase
   end

   // R2: reserved positions of the status words read as zero
   a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_i == A_RAW || addr_i == A_MIS) |-> ((rdata_o & ~IMPL_MASK) == '0));
   // R3: no enabled source means no interrupt
   a_r3_no_mask_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |-> !irq_o);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
   import uart_irq_pkg::*;
#(
   parameter int unsigned FIFO_DEPTH = 16,
   parameter int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] evt_i,
   input  logic [LVL_W-1:0]  tx_level_i,
   input  logic [LVL_W-1:0]  rx_level_i,
   input  logic              tx_wr_i,
   input  logic              rx_rd_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic              reg_wr_i,
   input  logic [STAT_W-1:0] reg_wdata_i,
   output logic [STAT_W-1:0] reg_rdata_o,
   output logic              irq_o
);

   localparam logic [STAT_W-1:0] TO_BIT = STAT_W'(1) << B_TIMEOUT;

   generate
      if (FIFO_DEPTH < 8 || (FIFO_DEPTH % 8) != 0) begin : g_bad_depth
         $error("FIFO_DEPTH must be a nonzero multiple of 8");
      end
      if ((1 << LVL_W) <= FIFO_DEPTH) begin : g_bad_lvl
         $error("LVL_W too narrow for FIFO_DEPTH");
      end
   endgenerate

   ctrl_t             ctrl;
   logic [STAT_W-1:0] mask, sw_clr, raw_q, raw_vis, set_vec, clr_vec;
   logic [LVL_W-1:0]  tx_thr, rx_thr, tx_thr_p1;
   logic              tx_up, tx_down, tx_empty, rx_up, rx_down, rx_fill;
   logic              tx_set, tx_clr, rx_set, rx_clr;

   assign tx_thr    = LVL_W'(trig_level(ctrl.tx_sel, FIFO_DEPTH));
   assign rx_thr    = LVL_W'(trig_level(ctrl.rx_sel, FIFO_DEPTH));
   assign tx_thr_p1 = tx_thr + LVL_W'(1);

   uart_irq_xing #(.LVL_W(LVL_W), .DRAIN(1'b1)) u_tx_xing (
      .clk(clk), .rst_n(rst_n), .level_i(tx_level_i), .thr_i(tx_thr_p1),
      .up_o(tx_up), .down_o(tx_down), .edge_o(tx_empty));

   uart_irq_xing #(.LVL_W(LVL_W), .DRAIN(1'b0)) u_rx_xing (
      .clk(clk), .rst_n(rst_n), .level_i(rx_level_i), .thr_i(rx_thr),
      .up_o(rx_up), .down_o(rx_down), .edge_o(rx_fill));

   always_comb begin
      if (ctrl.eot_mode)     tx_set = evt_i[B_EOT];
      else if (ctrl.fifo_en) tx_set = tx_down;
      else                   tx_set = tx_empty;
      tx_clr = ctrl.fifo_en ? tx_up   : tx_wr_i;
      rx_set = ctrl.fifo_en ? rx_up   : rx_fill;
      rx_clr = ctrl.fifo_en ? rx_down : rx_rd_i;
   end

   always_comb begin
      set_vec = evt_i & IMPL_MASK & ~FIFO_BITS;
      set_vec[B_TX_FIFO] = tx_set;
      set_vec[B_RX_FIFO] = rx_set;
      clr_vec = sw_clr;
      clr_vec[B_TX_FIFO] = sw_clr[B_TX_FIFO] | tx_clr;
      clr_vec[B_RX_FIFO] = sw_clr[B_RX_FIFO] | rx_clr;
   end

   uart_irq_stat #(.W(STAT_W), .IMPL(IMPL_MASK)) u_stat (
      .clk(clk), .rst_n(rst_n), .set_i(set_vec), .clr_i(clr_vec), .q_o(raw_q));

   assign raw_vis = mask[B_TIMEOUT] ? raw_q : (raw_q & ~TO_BIT);

   uart_irq_regs #(.DW(STAT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr_i(reg_addr_i), .wr_i(reg_wr_i),
      .wdata_i(reg_wdata_i), .raw_vis_i(raw_vis), .rdata_o(reg_rdata_o),
      .mask_o(mask), .clr_o(sw_clr), .ctrl_o(ctrl), .irq_o(irq_o));

   // R9: in end-of-transmission mode the transmit flag rises only after an EOT event
   a_r9_eot_source: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(raw_q[B_TX_FIFO]) && $past(ctrl.eot_mode)) |-> $past(evt_i[B_EOT]));
   // R8: the receive flag never rises out of an empty receive side
   a_r8_rx_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(raw_q[B_RX_FIFO]) |-> ($past(rx_level_i) != '0));
   // R10: a hidden timeout never shows on the raw read port
   a_r10_timeout_hidden: assert property (@(posedge clk) disable iff (!rst_n)
      (!mask[B_TIMEOUT] && reg_addr_i == A_RAW) |-> !reg_rdata_o[B_TIMEOUT]);

endmodule

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] evt = '0;
   logic [4:0]  txl = '0, rxl = '0;
   logic        tx_wr = 1'b0, rx_rd = 1'b0;
   logic [2:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   uart_irq_ctrl dut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .tx_level_i(txl), .rx_level_i(rxl),
      .tx_wr_i(tx_wr), .rx_rd_i(rx_rd), .reg_addr_i(addr), .reg_wr_i(wr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq));

   typedef struct packed {
      logic [4:0] rxl;
      logic [4:0] txl;
      logic       erx;
      logic       etx;
   } vec_t;

   // receive trigger 4, transmit trigger 8, FIFO mode
   localparam vec_t VECS [10] = '{
      '{5'd2,  5'd10, 1'b0, 1'b0},
      '{5'd4,  5'd12, 1'b1, 1'b0},
      '{5'd6,  5'd9,  1'b1, 1'b0},
      '{5'd3,  5'd8,  1'b0, 1'b1},
      '{5'd5,  5'd5,  1'b1, 1'b1},
      '{5'd7,  5'd10, 1'b1, 1'b0},
      '{5'd2,  5'd3,  1'b0, 1'b1},
      '{5'd4,  5'd3,  1'b1, 1'b1},
      '{5'd16, 5'd16, 1'b1, 1'b0},
      '{5'd0,  5'd0,  1'b0, 1'b1}
   };

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      tick;
      wr = 1'b0; wdata = '0;
   endtask

   task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic pulse_evt(input logic [31:0] v);
      evt = v;
      tick;
      evt = '0;
   endtask

   function automatic int exp_trig(input int s);
      case (s)
         0: return 2;
         1: return 4;
         2: return 8;
         3: return 12;
         4: return 14;
         default: return 8;
      endcase
   endfunction

   initial begin
      #3_000_000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      reg_read(3'd0, d); chk("R1 raw", d, 32'h0);
      reg_read(3'd1, d); chk("R1 mask", d, 32'h0);
      reg_read(3'd2, d); chk("R1 masked", d, 32'h0);
      reg_read(3'd4, d); chk("R1 ctrl", d, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);

      // R2 every event at once; FIFO, reserved and hidden timeout excluded
      pulse_evt(32'hFFFF_FFFF);
      reg_read(3'd0, d); chk("R2 raw layout", d, 32'h0003_1F8F);
      chk("R3 irq with empty mask", {31'b0, irq}, 32'h0);

      // R10 timeout becomes visible with its mask bit
      reg_write(3'd1, 32'h0000_0040);
      reg_read(3'd0, d); chk("R10 raw shows timeout", d, 32'h0003_1FCF);
      reg_read(3'd2, d); chk("R10 masked", d, 32'h0000_0040);
      chk("R10 irq", {31'b0, irq}, 32'h1);

      // R3 masking
      reg_write(3'd1, 32'h0000_0081);
      reg_read(3'd1, d); chk("R3 mask readback", d, 32'h0000_0081);
      reg_read(3'd2, d); chk("R3 masked", d, 32'h0000_0081);
      chk("R3 irq", {31'b0, irq}, 32'h1);

      // R4 clearing
      reg_write(3'd3, 32'h0);
      reg_read(3'd0, d); chk("R4 zero clear no effect", d, 32'h0003_1F8F);
      reg_write(3'd0, 32'h0);
      reg_read(3'd0, d); chk("R4 raw write ignored", d, 32'h0003_1F8F);
      reg_write(3'd3, 32'h0000_0001);
      reg_read(3'd0, d); chk("R4 single clear", d, 32'h0003_1F8E);
      reg_read(3'd2, d); chk("R4 masked after clear", d, 32'h0000_0080);
      reg_write(3'd3, 32'hFFFF_FFFF);
      reg_write(3'd1, 32'h0000_0040);
      reg_read(3'd0, d); chk("R4 all cleared incl timeout", d, 32'h0);
      chk("R4 irq low", {31'b0, irq}, 32'h0);
      reg_write(3'd1, 32'h0);

      // R5 set beats clear in the same cycle
      evt = 32'h0000_0200;
      addr = 3'd3; wdata = 32'h0000_0200; wr = 1'b1;
      tick;
      evt = '0; wr = 1'b0; wdata = '0;
      reg_read(3'd0, d); chk("R5 set wins", d, 32'h0000_0200);
      reg_write(3'd3, 32'hFFFF_FFFF);

      // R6 / R7 crossing table
      reg_write(3'd4, 32'h0000_0029);
      for (int i = 0; i < 10; i++) begin
         rxl = VECS[i].rxl;
         txl = VECS[i].txl;
         tick;
         reg_read(3'd0, d);
         chk($sformatf("R6 rx step %0d", i), {31'b0, d[4]}, {31'b0, VECS[i].erx});
         chk($sformatf("R7 tx step %0d", i), {31'b0, d[5]}, {31'b0, VECS[i].etx});
      end
      reg_write(3'd3, 32'hFFFF_FFFF);

      // R9 end-of-transmission mode
      reg_write(3'd4, 32'h0000_002B);
      txl = 5'd10; tick;
      txl = 5'd3;  tick;
      reg_read(3'd0, d); chk("R9 crossing ignored", d, 32'h0);
      pulse_evt(32'h0000_0800);
      reg_read(3'd0, d); chk("R9 eot sets tx", d, 32'h0000_0820);
      reg_write(3'd3, 32'hFFFF_FFFF);
      txl = 5'd0; tick;

      // R8 FIFOs off
      reg_write(3'd4, 32'h0);
      rxl = 5'd1; tick;
      reg_read(3'd0, d); chk("R8 rx holding full", d, 32'h0000_0010);
      rx_rd = 1'b1; tick; rx_rd = 1'b0;
      reg_read(3'd0, d); chk("R8 rx read clears", d, 32'h0);
      txl = 5'd2; tick;
      txl = 5'd0; tick;
      reg_read(3'd0, d); chk("R8 tx holding empty", d, 32'h0000_0020);
      tx_wr = 1'b1; tick; tx_wr = 1'b0;
      reg_read(3'd0, d); chk("R8 tx write clears", d, 32'h0);
      pulse_evt(32'h0000_E030);
      reg_read(3'd0, d); chk("R2 fifo and reserved events ignored", d, 32'h0);
      rxl = 5'd0; tick;

      // R11 trigger select sweep
      for (int s = 0; s < 8; s++) begin
         int t;
         t = exp_trig(s);
         reg_write(3'd4, 32'h1 | (32'(s) << 5));
         rxl = 5'(t - 1); tick;
         reg_read(3'd0, d);
         chk($sformatf("R11 sel %0d below", s), {31'b0, d[4]}, 32'h0);
         rxl = 5'(t); tick;
         reg_read(3'd0, d);
         chk($sformatf("R11 sel %0d at", s), {31'b0, d[4]}, 32'h1);
         rxl = 5'd0; tick;
         reg_write(3'd3, 32'hFFFF_FFFF);
      end

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule